// File: doc/BRIEF.md
# RISC Instruction Decode Unit

This block turns one 32-bit instruction word of a fixed-length load/store instruction set into the controls a simple pipeline needs. It handles three formats: register (operation chosen by a function field), immediate (a 16-bit constant or offset), and jump (a 26-bit word index). It also takes the address of the instruction and returns the next sequential address, the PC-relative branch target and the region-relative jump target.

The decode itself is a single combinational layer. The results are captured in one output register stage, so every output reflects the word and PC presented at the previous rising clock edge. The block chooses the write-back register for each format. It picks sign, zero or upper-half placement for the immediate according to the instruction class. It flags any word it does not recognise and keeps that word from causing side effects. The register file, ALU, memory, delay-slot sequencing and trap handling lie outside this block.

Top module: `rdec_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge, including `illegal`, `reg_we`, `mem_re`, `mem_we`, `is_branch`, `is_jump` and `link`.
- R2: One edge after `instr` and `pc` are sampled, `rs_idx` = instr[25:21], `rt_idx` = instr[20:16] and `shamt` = instr[10:6]. This holds for every word, legal or not.
- R3: When `reg_we` is 1, `wr_idx` has one of three values. For op = 0 it is instr[15:11]. For the immediate ALU and load opcodes it is instr[20:16]. For jump-and-link it is 31.
- R4: For and-immediate (op 12) and or-immediate (op 13), `imm` = {16'b0, instr[15:0]}.
- R5: Eight opcodes give `imm` as instr[15:0] sign-extended to 32 bits: add-immediate (op 8), add-immediate-unsigned (op 9), set-less-immediate (op 10), set-less-immediate-unsigned (op 11), load word (op 35), store word (op 43), branch-equal (op 4) and branch-not-equal (op 5). Every other word gives `imm` = 0, except those covered by R4 and R6.
- R6: For load-upper (op 15), `imm` = {instr[15:0], 16'b0}.
- R7: `alu_op` uses these codes: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than, 7 unsigned less-than, 8 shift-left, 9 logical shift-right, 10 arithmetic shift-right, 11 pass immediate. For op 0 the function field selects the code: 32 and 33 give 0, 34 and 35 give 1, 36 gives 2, 37 gives 3, 38 gives 4, 39 gives 5, 42 gives 6, 43 gives 7, 0 gives 8, 2 gives 9, 3 gives 10. The immediate opcodes use these codes: ops 8, 9, 35 and 43 give 0, op 10 gives 6, op 11 gives 7, op 12 gives 2, op 13 gives 3, op 15 gives 11, and branches give 1. Jumps and illegal words give 0.
- R8: Load word (op 35) sets `mem_re` and `reg_we`. Store word (op 43) sets `mem_we` only. No word sets both memory enables.
- R9: Op 4 sets `is_branch`. Op 5 sets both `is_branch` and `branch_ne`. Neither writes a register. For every word, `br_target` = pc + 4 + (sign-extended instr[15:0] << 2).
- R10: Jump (op 2) sets `is_jump`. Jump-and-link (op 3) also sets `link` and `reg_we`. For every word, `pc_plus4` = pc + 4 and `jmp_target` = {pc_plus4[31:28], instr[25:0], 2'b00}.
- R11: Jump-register (op 0, function 8) sets `is_jump` and `jump_reg` and does not write a register.
- R12: Two kinds of word are illegal: any opcode outside {0, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 15, 35, 43}, and op 0 with a function outside {0, 2, 3, 8, 32 to 39, 42, 43}. Such a word sets `illegal` and clears `reg_we`, `mem_re`, `mem_we`, `is_branch`, `branch_ne`, `is_jump`, `jump_reg` and `link`. Its `imm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| wr_idx | output | 5 | Write-back register index |
| shamt | output | 5 | Shift amount field |
| imm | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| reg_we | output | 1 | Register write enable |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| is_branch | output | 1 | Conditional branch |
| branch_ne | output | 1 | Branch condition is inequality |
| is_jump | output | 1 | Unconditional transfer |
| jump_reg | output | 1 | Target comes from the first source register |
| link | output | 1 | Return address goes to register 31 |
| illegal | output | 1 | Unrecognised instruction |
| pc_plus4 | output | 32 | Sequential address, also the link value |
| br_target | output | 32 | PC-relative branch target |
| jmp_target | output | 32 | Region-relative jump target |

## Verification
A wrong opcode or function entry in the decode table shows up as a wrong enable, index, code or immediate on the outputs. It appears exactly one edge after the offending word is applied, and nothing is hidden across cycles, so a sweep of all 64 opcodes and all 64 function values exposes each entry directly. Corruption in the extension or target logic appears as a wrong `imm`, `br_target` or `jmp_target` in the same cycle. Operand values at the sign boundary and PCs that wrap or sit at the top of the address space make such errors visible.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int ILEN   = 32;
  localparam int REG_AW = 5;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,  ALU_SUB  = 4'd1,  ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_XOR  = 4'd4,  ALU_NOR  = 4'd5,  ALU_SLT = 4'd6, ALU_SLTU = 4'd7,
    ALU_SLL  = 4'd8,  ALU_SRL  = 4'd9,  ALU_SRA = 4'd10, ALU_PASS = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {IMK_NONE, IMK_SIGN, IMK_ZERO, IMK_UPPER} imm_kind_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;

  typedef struct packed {
    alu_op_e   alu;
    imm_kind_e ik;
    dst_sel_e  dst;
    logic      reg_we;
    logic      mem_re;
    logic      mem_we;
    logic      br;
    logic      br_ne;
    logic      jmp;
    logic      jreg;
    logic      link;
    logic      illegal;
  } ctrl_t;

  localparam logic [OP_W-1:0] OPC_REG   = 6'd0,  OPC_J    = 6'd2,  OPC_JAL  = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4,  OPC_BNE  = 6'd5;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8,  OPC_ADDIU = 6'd9, OPC_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OPC_SLTIU = 6'd11, OPC_ANDI = 6'd12, OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'd15, OPC_LW   = 6'd35, OPC_SW   = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0,  FN_SRL = 6'd2,  FN_SRA = 6'd3,  FN_JR = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32, FN_ADDU = 6'd33, FN_SUB = 6'd34, FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND = 6'd36, FN_OR  = 6'd37, FN_XOR = 6'd38, FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42, FN_SLTU = 6'd43;
endpackage

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
  import rdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [5:0]      funct,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{alu: ALU_ADD, ik: IMK_NONE, dst: DST_RD, default: 1'b0};
    unique case (op)
      OPC_REG: begin
        ctrl.reg_we = 1'b1;
        unique case (funct)
          FN_ADD, FN_ADDU: ctrl.alu = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.alu = ALU_SUB;
          FN_AND:          ctrl.alu = ALU_AND;
          FN_OR:           ctrl.alu = ALU_OR;
          FN_XOR:          ctrl.alu = ALU_XOR;
          FN_NOR:          ctrl.alu = ALU_NOR;
          FN_SLT:          ctrl.alu = ALU_SLT;
          FN_SLTU:         ctrl.alu = ALU_SLTU;
          FN_SLL:          ctrl.alu = ALU_SLL;
          FN_SRL:          ctrl.alu = ALU_SRL;
          FN_SRA:          ctrl.alu = ALU_SRA;
          FN_JR: begin
            ctrl.reg_we = 1'b0;
            ctrl.jmp    = 1'b1;
            ctrl.jreg   = 1'b1;
          end
          default: begin
            ctrl.reg_we  = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OPC_ADDI, OPC_ADDIU: begin
        ctrl.ik = IMK_SIGN; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.alu = ALU_SLT; ctrl.ik = IMK_SIGN; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_SLTIU: begin
        ctrl.alu = ALU_SLTU; ctrl.ik = IMK_SIGN; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_ANDI: begin
        ctrl.alu = ALU_AND; ctrl.ik = IMK_ZERO; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_ORI: begin
        ctrl.alu = ALU_OR; ctrl.ik = IMK_ZERO; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_LUI: begin
        ctrl.alu = ALU_PASS; ctrl.ik = IMK_UPPER; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1;
      end
      OPC_LW: begin
        ctrl.ik = IMK_SIGN; ctrl.dst = DST_RT; ctrl.reg_we = 1'b1; ctrl.mem_re = 1'b1;
      end
      OPC_SW: begin
        ctrl.ik = IMK_SIGN; ctrl.mem_we = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.alu = ALU_SUB; ctrl.ik = IMK_SIGN; ctrl.br = 1'b1;
      end
      OPC_BNE: begin
        ctrl.alu = ALU_SUB; ctrl.ik = IMK_SIGN; ctrl.br = 1'b1; ctrl.br_ne = 1'b1;
      end
      OPC_J:   ctrl.jmp = 1'b1;
      OPC_JAL: begin
        ctrl.jmp = 1'b1; ctrl.link = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = DST_LINK;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
  import rdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [IMM_W-1:0] raw,
  input  imm_kind_e        kind,
  output logic [XLEN-1:0]  ext
);
  localparam int PAD = XLEN - IMM_W;

  always_comb begin
    unique case (kind)
      IMK_SIGN:  ext = {{PAD{raw[IMM_W-1]}}, raw};
      IMK_ZERO:  ext = {{PAD{1'b0}}, raw};
      IMK_UPPER: ext = {raw, {PAD{1'b0}}};
      default:   ext = '0;
    endcase
  end
endmodule

// File: rtl/rdec_target.sv
module rdec_target
  import rdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  offs,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   seq,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   jmp_tgt
);
  localparam int REGION = XLEN - JIDX_W - 2;
  localparam int SPAD   = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offs_sh;

  always_comb begin
    seq     = pc + XLEN'(4);
    offs_sh = {{SPAD{offs[IMM_W-1]}}, offs, 2'b00};
    br_tgt  = seq + offs_sh;
    jmp_tgt = {seq[XLEN-1 -: REGION], jidx, 2'b00};
  end
endmodule

// File: rtl/rdec_top.sv
module rdec_top
  import rdec_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ILEN-1:0]   instr,
  input  logic [XLEN-1:0]   pc,
  output logic [REG_AW-1:0] rs_idx,
  output logic [REG_AW-1:0] rt_idx,
  output logic [REG_AW-1:0] wr_idx,
  output logic [REG_AW-1:0] shamt,
  output logic [XLEN-1:0]   imm,
  output logic [3:0]        alu_op,
  output logic              reg_we,
  output logic              mem_re,
  output logic              mem_we,
  output logic              is_branch,
  output logic              branch_ne,
  output logic              is_jump,
  output logic              jump_reg,
  output logic              link,
  output logic              illegal,
  output logic [XLEN-1:0]   pc_plus4,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   jmp_target
);
  logic [OP_W-1:0]   f_op;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, f_sh;
  logic [5:0]        f_fn;
  ctrl_t             ctrl;
  logic [XLEN-1:0]   imm_c, seq_c, brt_c, jmt_c;
  logic [REG_AW-1:0] dst_c;

  assign f_op = instr[31:26];
  assign f_rs = instr[25:21];
  assign f_rt = instr[20:16];
  assign f_rd = instr[15:11];
  assign f_sh = instr[10:6];
  assign f_fn = instr[5:0];

  rdec_ctrl u_ctrl (.op(f_op), .funct(f_fn), .ctrl(ctrl));

  rdec_imm #(.XLEN(XLEN)) u_imm (
    .raw(instr[IMM_W-1:0]), .kind(ctrl.ik), .ext(imm_c)
  );

  rdec_target #(.XLEN(XLEN)) u_tgt (
    .pc(pc), .offs(instr[IMM_W-1:0]), .jidx(instr[JIDX_W-1:0]),
    .seq(seq_c), .br_tgt(brt_c), .jmp_tgt(jmt_c)
  );

  always_comb begin
    unique case (ctrl.dst)
      DST_RT:   dst_c = f_rt;
      DST_LINK: dst_c = REG_AW'(LINK_IDX);
      default:  dst_c = f_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_idx <= '0; rt_idx <= '0; wr_idx <= '0; shamt <= '0;
      imm <= '0; alu_op <= '0;
      reg_we <= 1'b0; mem_re <= 1'b0; mem_we <= 1'b0;
      is_branch <= 1'b0; branch_ne <= 1'b0; is_jump <= 1'b0;
      jump_reg <= 1'b0; link <= 1'b0; illegal <= 1'b0;
      pc_plus4 <= '0; br_target <= '0; jmp_target <= '0;
    end else begin
      rs_idx     <= f_rs;
      rt_idx     <= f_rt;
      wr_idx     <= dst_c;
      shamt      <= f_sh;
      imm        <= imm_c;
      alu_op     <= ctrl.alu;
      reg_we     <= ctrl.reg_we;
      mem_re     <= ctrl.mem_re;
      mem_we     <= ctrl.mem_we;
      is_branch  <= ctrl.br;
      branch_ne  <= ctrl.br_ne;
      is_jump    <= ctrl.jmp;
      jump_reg   <= ctrl.jreg;
      link       <= ctrl.link;
      illegal    <= ctrl.illegal;
      pc_plus4   <= seq_c;
      br_target  <= brt_c;
      jmp_target <= jmt_c;
    end
  end
endmodule

// File: rtl/rdec_checker.sv
module rdec_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [4:0]  rs_idx,
  input logic [4:0]  rt_idx,
  input logic [4:0]  wr_idx,
  input logic [4:0]  shamt,
  input logic [31:0] imm,
  input logic        reg_we,
  input logic        mem_re,
  input logic        mem_we,
  input logic        is_branch,
  input logic        is_jump,
  input logic        link,
  input logic        illegal,
  input logic [31:0] pc_plus4,
  input logic [31:0] jmp_target
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_fields_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (rs_idx == $past(instr[25:21]) && rt_idx == $past(instr[20:16])
               && shamt == $past(instr[10:6])));

  assert_rdest_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && reg_we && $past(instr[31:26]) == 6'd0) |-> wr_idx == $past(instr[15:11]));

  assert_lui_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(instr[31:26]) == 6'd15) |-> imm == {$past(instr[15:0]), 16'h0000});

  assert_mem_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  assert_link_dest_R10: assert property (@(posedge clk) disable iff (rst)
    link |-> (reg_we && wr_idx == 5'd31 && is_jump));

  assert_seq_R10: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pc_plus4 == $past(pc) + 32'd4
               && jmp_target == {pc_plus4[31:28], $past(instr[25:0]), 2'b00}));

  assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !(reg_we || mem_re || mem_we || is_branch || is_jump || link));
endmodule

bind rdec_top rdec_checker u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pc(pc),
  .rs_idx(rs_idx), .rt_idx(rt_idx), .wr_idx(wr_idx), .shamt(shamt), .imm(imm),
  .reg_we(reg_we), .mem_re(mem_re), .mem_we(mem_we), .is_branch(is_branch),
  .is_jump(is_jump), .link(link), .illegal(illegal),
  .pc_plus4(pc_plus4), .jmp_target(jmp_target)
);

// File: tb/rdec_top_tb.sv
`timescale 1ns/1ps
module rdec_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [4:0]  rs_idx, rt_idx, wr_idx, shamt;
  logic [31:0] imm, pc_plus4, br_target, jmp_target;
  logic [3:0]  alu_op;
  logic reg_we, mem_re, mem_we, is_branch, branch_ne, is_jump, jump_reg, link, illegal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rdec_top u_dut (
    .clk(clk), .rst(rst), .instr(instr), .pc(pc),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .wr_idx(wr_idx), .shamt(shamt), .imm(imm),
    .alu_op(alu_op), .reg_we(reg_we), .mem_re(mem_re), .mem_we(mem_we),
    .is_branch(is_branch), .branch_ne(branch_ne), .is_jump(is_jump),
    .jump_reg(jump_reg), .link(link), .illegal(illegal),
    .pc_plus4(pc_plus4), .br_target(br_target), .jmp_target(jmp_target)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [31:0] w, input logic [31:0] p);
    logic [5:0] op, fn;
    logic [31:0] sx, zx, e_imm, e_seq;
    logic [3:0] e_alu;
    logic e_we, e_re, e_mw, e_br, e_ne, e_j, e_jr, e_lk, e_ill;
    logic [4:0] e_wr;
    op = w[31:26]; fn = w[5:0];
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'h0000, w[15:0]};
    e_imm = 0; e_alu = 0; e_we = 0; e_re = 0; e_mw = 0; e_br = 0; e_ne = 0;
    e_j = 0; e_jr = 0; e_lk = 0; e_ill = 0; e_wr = w[20:16];
    case (op)
      6'd0: begin
        e_wr = w[15:11]; e_we = 1;
        case (fn)
          6'd32, 6'd33: e_alu = 0;
          6'd34, 6'd35: e_alu = 1;
          6'd36: e_alu = 2;
          6'd37: e_alu = 3;
          6'd38: e_alu = 4;
          6'd39: e_alu = 5;
          6'd42: e_alu = 6;
          6'd43: e_alu = 7;
          6'd0:  e_alu = 8;
          6'd2:  e_alu = 9;
          6'd3:  e_alu = 10;
          6'd8:  begin e_we = 0; e_j = 1; e_jr = 1; end
          default: begin e_we = 0; e_ill = 1; end
        endcase
      end
      6'd8, 6'd9: begin e_imm = sx; e_we = 1; end
      6'd10: begin e_imm = sx; e_we = 1; e_alu = 6; end
      6'd11: begin e_imm = sx; e_we = 1; e_alu = 7; end
      6'd12: begin e_imm = zx; e_we = 1; e_alu = 2; end
      6'd13: begin e_imm = zx; e_we = 1; e_alu = 3; end
      6'd15: begin e_imm = {w[15:0], 16'h0000}; e_we = 1; e_alu = 11; end
      6'd35: begin e_imm = sx; e_we = 1; e_re = 1; end
      6'd43: begin e_imm = sx; e_mw = 1; end
      6'd4:  begin e_imm = sx; e_br = 1; e_alu = 1; end
      6'd5:  begin e_imm = sx; e_br = 1; e_ne = 1; e_alu = 1; end
      6'd2:  e_j = 1;
      6'd3:  begin e_j = 1; e_lk = 1; e_we = 1; e_wr = 5'd31; end
      default: e_ill = 1;
    endcase
    e_seq = p + 32'd4;

    @(negedge clk);
    instr = w; pc = p;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "rs_idx", 32'(rs_idx), 32'(w[25:21]));
    chk("R2", "rt_idx", 32'(rt_idx), 32'(w[20:16]));
    chk("R2", "shamt",  32'(shamt),  32'(w[10:6]));
    if (e_we) chk("R3", "wr_idx", 32'(wr_idx), 32'(e_wr));
    if (op == 6'd12 || op == 6'd13) chk("R4", "imm", imm, e_imm);
    else if (op == 6'd15)           chk("R6", "imm", imm, e_imm);
    else                            chk("R5", "imm", imm, e_imm);
    chk("R7", "alu_op", 32'(alu_op), 32'(e_alu));
    chk("R8", "mem_re", 32'(mem_re), 32'(e_re));
    chk("R8", "mem_we", 32'(mem_we), 32'(e_mw));
    chk("R9", "is_branch", 32'(is_branch), 32'(e_br));
    chk("R9", "branch_ne", 32'(branch_ne), 32'(e_ne));
    chk("R9", "br_target", br_target, e_seq + {sx[29:0], 2'b00});
    chk("R10", "is_jump", 32'(is_jump), 32'(e_j));
    chk("R10", "link", 32'(link), 32'(e_lk));
    chk("R10", "pc_plus4", pc_plus4, e_seq);
    chk("R10", "jmp_target", jmp_target, {e_seq[31:28], w[25:0], 2'b00});
    chk("R11", "jump_reg", 32'(jump_reg), 32'(e_jr));
    chk("R12", "illegal", 32'(illegal), 32'(e_ill));
    chk(e_ill ? "R12" : "R3", "reg_we", 32'(reg_we), 32'(e_we));
  endtask

  initial begin
    logic [31:0] pcs [3];
    logic [15:0] imms [4];
    pcs[0] = 32'h0040_0010; pcs[1] = 32'hF000_0FFC; pcs[2] = 32'hFFFF_FFFC;
    imms[0] = 16'h8001; imms[1] = 16'h7FFE; imms[2] = 16'h0000; imms[3] = 16'hFFFF;

    instr = 32'h2262_0005;
    pc = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held clear under reset
    chk("R1", "illegal", 32'(illegal), 0);
    chk("R1", "reg_we", 32'(reg_we), 0);
    chk("R1", "mem_re|mem_we", 32'(mem_re | mem_we), 0);
    chk("R1", "branch|jump|link", 32'(is_branch | is_jump | link), 0);
    chk("R1", "imm", imm, 0);
    chk("R1", "pc_plus4", pc_plus4, 0);
    rst = 1'b0;

    for (int o = 0; o < 64; o++)
      for (int k = 0; k < 4; k++)
        for (int q = 0; q < 3; q++)
          apply_and_check({6'(o), 5'd3, 5'd7, imms[k]} ^ (k == 3 ? 32'h03FF_0000 : 0), pcs[q]);

    for (int f = 0; f < 64; f++)
      for (int q = 0; q < 3; q++)
        apply_and_check({6'd0, 5'd17, 5'd9, 5'd22, 5'(f + q), 6'(f)}, pcs[q]);

    apply_and_check({6'd3, 26'h3FF_FFFF}, 32'hFFFF_FFFC);
    apply_and_check({6'd5, 5'd1, 5'd2, 16'h8000}, 32'h0000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule